// File: doc/BRIEF.md
# Almost-Flag Offset Configuration Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compare against. The almost-empty offset counts words from the empty boundary, and the almost-full offset counts free words from the full boundary. The block is configured only during a full reset. On every clock edge while full reset is asserted, it samples a 3-bit select input and a parity-layout input. The select code either loads one of five fixed offsets into both registers, or clears both registers and arms one of two programming paths.

In parallel programming, the first two accepted writes on the write-side bus supply the almost-empty offset and then the almost-full offset. In serial programming, one bit per enabled clock is taken from a serial input. The almost-empty offset comes in first, then the almost-full offset, each most significant bit first. A parity-layout choice made at full reset decides whether bit 8 of a parallel word is part of the offset or is a parity slot that gets skipped. Once both offsets are present, a done flag rises and ordinary FIFO writes pass through. A partial reset flushes the FIFO elsewhere but leaves everything in this block untouched.

Top module: `oc_loader`

## Requirements
- R1: While full reset is low, select codes map to fixed offsets: 0 gives 8, 1 gives 16, 2 gives 64, 3 gives 256, 4 gives 1024, and 7 gives 8. Both offsets take the same value, and `prog_done` is 1 on the first cycle after full reset is released.
- R2: Select code 5 (serial) and code 6 (parallel) clear both offsets to 0 and leave `prog_done` at 0 after full reset.
- R3: In parallel mode, the first write with `wr_en` high loads the almost-empty offset from `prog_data`. The second such write loads the almost-full offset and sets `prog_done`. Writes after that change neither offset.
- R4: With parity layout off (`parity_sel` 0 at full reset), a parallel offset equals `prog_data[OFF_W-1:0]`, and bit 8 is a normal offset bit.
- R5: With parity layout on, `prog_data[8]` is ignored. The offset is `{prog_data[OFF_W:9], prog_data[7:0]}`, so the bits above 8 move down by one.
- R6: In serial mode, each clock with `ser_en` high shifts in one bit of `ser_din`. The first OFF_W bits form the almost-empty offset and the next OFF_W bits form the almost-full offset, each MSB first. `prog_done` rises with bit 2*OFF_W, and later bits are ignored.
- R7: While `part_rst_n` is low, the offsets, mode, parity layout and `prog_done` do not change. A parallel write or serial bit presented in the same cycle is discarded.
- R8: `fifo_wr_en` is high only when `wr_en` is high and `prog_done` is 1.
- R9: After full reset is released, changes on `sel` and `parity_sel` have no effect until the next full reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the write side |
| full_rst_n | input | 1 | Full reset, active low; configuration is sampled while it is low |
| part_rst_n | input | 1 | Partial reset, active low; holds all settings |
| sel | input | 3 | Offset/programming select, sampled during full reset |
| parity_sel | input | 1 | Parity layout select (1 = bit 8 skipped), sampled during full reset |
| wr_en | input | 1 | Write request from the write side |
| prog_data | input | OFF_W+1 | Low bits of the write-side data bus |
| ser_en | input | 1 | Serial bit enable |
| ser_din | input | 1 | Serial offset data |
| ae_off | output | OFF_W | Almost-empty offset |
| af_off | output | OFF_W | Almost-full offset |
| prog_done | output | 1 | Both offsets are valid |
| fifo_wr_en | output | 1 | Write passed on to the FIFO |

## Verification
A partial reset and a programming step can land on the same clock edge. Two cases are provoked: a parallel write issued while `part_rst_n` is low, and the last serial bit presented during a partial reset. Each case is judged at the ports: the offset that write or bit would have filled must keep its old value and `prog_done` must stay low. The same step is then repeated after the partial reset is released, and it must take effect normally.

// File: rtl/oc_pkg.sv
package oc_pkg;
   typedef enum logic [1:0] {
      MODE_FIXED  = 2'd0,
      MODE_SERIAL = 2'd1,
      MODE_PARALL = 2'd2
   } oc_mode_e;

   localparam logic [2:0] SEL_SERIAL = 3'd5;
   localparam logic [2:0] SEL_PARALL = 3'd6;
endpackage

// File: rtl/oc_default_sel.sv
module oc_default_sel
   import oc_pkg::*;
#(
   parameter int OFF_W = 13
) (
   input  logic [2:0]       sel,
   output oc_mode_e         mode,
   output logic [OFF_W-1:0] fixed_off
);
   always_comb begin
      mode      = MODE_FIXED;
      fixed_off = OFF_W'(8);
      case (sel)
         3'd0:       fixed_off = OFF_W'(8);
         3'd1:       fixed_off = OFF_W'(16);
         3'd2:       fixed_off = OFF_W'(64);
         3'd3:       fixed_off = OFF_W'(256);
         3'd4:       fixed_off = OFF_W'(1024);
         SEL_SERIAL: begin mode = MODE_SERIAL; fixed_off = '0; end
         SEL_PARALL: begin mode = MODE_PARALL; fixed_off = '0; end
         default:    fixed_off = OFF_W'(8);
      endcase
   end
endmodule

// File: rtl/oc_par_unpack.sv
module oc_par_unpack #(
   parameter int OFF_W  = 13,
   parameter int PAR_BIT = 8
) (
   input  logic [OFF_W:0]   word,
   input  logic             parity_on,
   output logic [OFF_W-1:0] off
);
   logic [OFF_W-1:0] plain_w;
   logic [OFF_W-1:0] packed_w;

   for (genvar i = 0; i < OFF_W; i++) begin : g_bit
      assign plain_w[i] = word[i];
      if (i < PAR_BIT) begin : g_low
         assign packed_w[i] = word[i];
      end else begin : g_high
         assign packed_w[i] = word[i+1];
      end
   end

   assign off = parity_on ? packed_w : plain_w;
endmodule

// File: rtl/oc_ser_count.sv
module oc_ser_count #(
   parameter int NBITS = 26
) (
   input  logic clk,
   input  logic clr,
   input  logic step,
   output logic last
);
   localparam int CNT_W = $clog2(NBITS);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (clr)       cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CNT_W'(NBITS - 1));
endmodule

// File: rtl/oc_loader.sv
module oc_loader
   import oc_pkg::*;
#(
   parameter int OFF_W = 13
) (
   input  logic             clk,
   input  logic             full_rst_n,
   input  logic             part_rst_n,
   input  logic [2:0]       sel,
   input  logic             parity_sel,
   input  logic             wr_en,
   input  logic [OFF_W:0]   prog_data,
   input  logic             ser_en,
   input  logic             ser_din,
   output logic [OFF_W-1:0] ae_off,
   output logic [OFF_W-1:0] af_off,
   output logic             prog_done,
   output logic             fifo_wr_en
);
   localparam int SER_BITS = 2 * OFF_W;

   if (OFF_W < 11) begin : g_chk_w
      $error("OFF_W must hold the largest fixed offset 1024");
   end

   oc_mode_e         mode_q, mode_d;
   logic             parity_q;
   logic             par_idx;
   logic [OFF_W-1:0] fixed_off;
   logic [OFF_W-1:0] par_off;
   logic             par_step, ser_step, ser_last;

   oc_default_sel #(.OFF_W(OFF_W)) u_sel (
      .sel       (sel),
      .mode      (mode_d),
      .fixed_off (fixed_off)
   );

   oc_par_unpack #(.OFF_W(OFF_W), .PAR_BIT(8)) u_unpack (
      .word      (prog_data),
      .parity_on (parity_q),
      .off       (par_off)
   );

   assign par_step = part_rst_n && wr_en  && !prog_done && (mode_q == MODE_PARALL);
   assign ser_step = part_rst_n && ser_en && !prog_done && (mode_q == MODE_SERIAL);

   oc_ser_count #(.NBITS(SER_BITS)) u_cnt (
      .clk  (clk),
      .clr  (!full_rst_n),
      .step (ser_step),
      .last (ser_last)
   );

   always_ff @(posedge clk) begin
      if (!full_rst_n) begin
         mode_q    <= mode_d;
         parity_q  <= parity_sel;
         ae_off    <= fixed_off;
         af_off    <= fixed_off;
         prog_done <= (mode_d == MODE_FIXED);
         par_idx   <= 1'b0;
      end else if (par_step) begin
         if (!par_idx) ae_off <= par_off;
         else begin
            af_off    <= par_off;
            prog_done <= 1'b1;
         end
         par_idx <= 1'b1;
      end else if (ser_step) begin
         ae_off <= {ae_off[OFF_W-2:0], af_off[OFF_W-1]};
         af_off <= {af_off[OFF_W-2:0], ser_din};
         if (ser_last) prog_done <= 1'b1;
      end
   end

   assign fifo_wr_en = wr_en && prog_done;
endmodule

// File: rtl/oc_loader_chk.sv
module oc_loader_chk #(
   parameter int OFF_W = 13
) (
   input logic             clk,
   input logic             full_rst_n,
   input logic             part_rst_n,
   input logic [2:0]       sel,
   input logic             wr_en,
   input logic [OFF_W-1:0] ae_off,
   input logic [OFF_W-1:0] af_off,
   input logic             prog_done,
   input logic             fifo_wr_en
);
   assert_fixed_code_R1: assert property (@(posedge clk) disable iff (!full_rst_n)
      $rose(full_rst_n) && $past(sel) == 3'd2 |->
         ae_off == OFF_W'(64) && af_off == OFF_W'(64) && prog_done);

   assert_prog_idle_R2: assert property (@(posedge clk) disable iff (!full_rst_n)
      $rose(full_rst_n) && ($past(sel) == 3'd5 || $past(sel) == 3'd6) |->
         ae_off == '0 && af_off == '0 && !prog_done);

   assert_done_holds_R3: assert property (@(posedge clk) disable iff (!full_rst_n)
      prog_done |=> prog_done && $stable(ae_off) && $stable(af_off));

   assert_part_hold_R7: assert property (@(posedge clk) disable iff (!full_rst_n)
      !part_rst_n |=> $stable(ae_off) && $stable(af_off) && $stable(prog_done));

   assert_wr_gate_R8: assert property (@(posedge clk) disable iff (!full_rst_n)
      wr_en && !prog_done |-> !fifo_wr_en);
endmodule

bind oc_loader oc_loader_chk #(.OFF_W(OFF_W)) u_chk (
   .clk        (clk),
   .full_rst_n (full_rst_n),
   .part_rst_n (part_rst_n),
   .sel        (sel),
   .wr_en      (wr_en),
   .ae_off     (ae_off),
   .af_off     (af_off),
   .prog_done  (prog_done),
   .fifo_wr_en (fifo_wr_en)
);

// File: tb/oc_loader_tb.sv
module oc_loader_tb;
   localparam int OFF_W = 13;

   logic             clk = 1'b0;
   logic             full_rst_n = 1'b0;
   logic             part_rst_n = 1'b1;
   logic [2:0]       sel = 3'd0;
   logic             parity_sel = 1'b0;
   logic             wr_en = 1'b0;
   logic [OFF_W:0]   prog_data = '0;
   logic             ser_en = 1'b0;
   logic             ser_din = 1'b0;
   logic [OFF_W-1:0] ae_off, af_off;
   logic             prog_done, fifo_wr_en;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   oc_loader #(.OFF_W(OFF_W)) u_dut (
      .clk(clk), .full_rst_n(full_rst_n), .part_rst_n(part_rst_n),
      .sel(sel), .parity_sel(parity_sel), .wr_en(wr_en),
      .prog_data(prog_data), .ser_en(ser_en), .ser_din(ser_din),
      .ae_off(ae_off), .af_off(af_off), .prog_done(prog_done),
      .fifo_wr_en(fifo_wr_en)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [OFF_W-1:0] squeeze(input logic [OFF_W:0] w);
      logic [OFF_W:0] hi;
      hi = (w >> 9) << 8;
      return OFF_W'(hi | {6'd0, w[7:0]});
   endfunction

   task automatic full_reset(input logic [2:0] code, input logic par);
      @(negedge clk);
      full_rst_n = 1'b0; sel = code; parity_sel = par;
      repeat (2) @(negedge clk);
      full_rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pwrite(input logic [OFF_W:0] d);
      wr_en = 1'b1; prog_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic sbit(input logic b);
      ser_en = 1'b1; ser_din = b;
      @(negedge clk);
      ser_en = 1'b0;
   endtask

   task automatic t_fixed;
      int vals [8] = '{8, 16, 64, 256, 1024, 0, 0, 8};
      for (int c = 0; c < 8; c++) begin
         full_reset(3'(c), 1'b0);
         if (c == 5 || c == 6) begin
            check("R2", "ae cleared", 32'(ae_off), 0);
            check("R2", "af cleared", 32'(af_off), 0);
            check("R2", "done low", 32'(prog_done), 0);
         end else begin
            check("R1", "ae fixed", 32'(ae_off), 32'(vals[c]));
            check("R1", "af fixed", 32'(af_off), 32'(vals[c]));
            check("R1", "done", 32'(prog_done), 1);
         end
      end
      sel = 3'd6; parity_sel = 1'b1;
      repeat (3) @(negedge clk);
      check("R9", "sel ignored ae", 32'(ae_off), 8);
      check("R9", "sel ignored done", 32'(prog_done), 1);
   endtask

   task automatic t_parallel_plain;
      full_reset(3'd6, 1'b0);
      wr_en = 1'b1; #1;
      check("R8", "write blocked", 32'(fifo_wr_en), 0);
      wr_en = 1'b0;
      pwrite(14'h0155);
      check("R4", "ae with bit8", 32'(ae_off), 32'h0155);
      check("R3", "done after one", 32'(prog_done), 0);
      pwrite(14'h3ABC);
      check("R4", "af low bits", 32'(af_off), 32'h1ABC);
      check("R3", "done after two", 32'(prog_done), 1);
      pwrite(14'h0007);
      check("R3", "later write ae", 32'(ae_off), 32'h0155);
      check("R3", "later write af", 32'(af_off), 32'h1ABC);
      wr_en = 1'b1; #1;
      check("R8", "write passes", 32'(fifo_wr_en), 1);
      wr_en = 1'b0;
   endtask

   task automatic t_parallel_parity;
      logic [OFF_W:0] a = 14'h2DA5;
      logic [OFF_W:0] b = 14'h017F;
      full_reset(3'd6, 1'b1);
      pwrite(a);
      check("R5", "ae squeezed", 32'(ae_off), 32'(squeeze(a)));
      pwrite(b);
      check("R5", "af squeezed", 32'(af_off), 32'(squeeze(b)));
      check("R5", "done", 32'(prog_done), 1);
   endtask

   task automatic t_serial;
      logic [2*OFF_W-1:0] stream = {13'h0ABC, 13'h1F05};
      full_reset(3'd5, 1'b0);
      for (int i = 2*OFF_W-1; i > 0; i--) sbit(stream[i]);
      check("R6", "done before last", 32'(prog_done), 0);
      part_rst_n = 1'b0;
      sbit(stream[0]);
      part_rst_n = 1'b1;
      check("R7", "last bit dropped", 32'(prog_done), 0);
      sbit(stream[0]);
      check("R6", "ae serial", 32'(ae_off), 32'h0ABC);
      check("R6", "af serial", 32'(af_off), 32'h1F05);
      check("R6", "done after last", 32'(prog_done), 1);
      sbit(1'b1); sbit(1'b0);
      check("R6", "extra bits ignored", 32'(af_off), 32'h1F05);
   endtask

   task automatic t_partial;
      full_reset(3'd6, 1'b0);
      part_rst_n = 1'b0;
      pwrite(14'h0123);
      check("R7", "write during partial", 32'(ae_off), 0);
      part_rst_n = 1'b1;
      pwrite(14'h0123);
      check("R7", "ae after release", 32'(ae_off), 32'h0123);
      part_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      pwrite(14'h0456);
      check("R7", "ae kept", 32'(ae_off), 32'h0123);
      check("R7", "done kept", 32'(prog_done), 0);
      part_rst_n = 1'b1;
      pwrite(14'h0456);
      check("R7", "af loaded", 32'(af_off), 32'h0456);
      check("R7", "done set", 32'(prog_done), 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_fixed();
      t_parallel_plain();
      t_parallel_parity();
      t_serial();
      t_partial();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule